// File: doc/BRIEF.md
# Infrared Run-Length Pulse Sampler

This block watches the output of an infrared receiver that has already removed the carrier. It resynchronises the line, can invert it, and samples it on a slow tick enable. It measures each stretch of constant level in ticks and stores the stretch as one byte in a 64-entry receive queue. The top bit of the byte holds the level and the low seven bits hold the tick count. Software, or a protocol decoder, reads the bytes through a small word-wide register port and adds up consecutive bytes of the same level to rebuild long pulses.

A packet starts when the sampled line first goes high. The packet ends when the line stays low for a programmable number of ticks. At that point the low run still being measured is flushed into the queue and a sticky packet-end flag is raised. When a run completes while the queue is full, the run is dropped and a sticky overflow flag is raised. A live level flag shows when the queue holds at least a programmable number of entries. The interrupt output is the OR of every flag whose enable bit is set.

Register map, selected by `reg_addr`. Address 0 is the data port: a read pops one entry. Address 1 is the status register: flag bits 7:0, clear one flag by writing 1 to its bit, entry count in bits 14:8. Address 2 is the interrupt enable register: enables in bits 7:0, level threshold in bits 14:8. Address 3 is the configuration register: bit 0 enables the receiver, bit 2 inverts the line, bits 31:16 hold the idle threshold in ticks, which must be at least 1.

Top module: `ir_run_sampler`

## Requirements
- R1: Each queue entry is a byte. Bit 7 is the sampled level of the run (1 high, 0 low). Bits 6:0 are the number of `tick` samples the run lasted. An entry is written when the sampled level changes.
- R2: A run of more than 127 ticks is stored as entries of 127 ticks each, all with the same level, followed by one entry holding the remainder (1 to 127).
- R3: Status bits 14:8 give the number of stored entries. A read of address 0 returns the oldest entry in bits 7:0 and removes it. A read of address 0 while the queue is empty returns 0.
- R4: When a run completes while 64 entries are stored, the run is discarded and overflow flag bit 0 of the status register is set.
- R5: While a packet is in progress, once the sampled line has been low for the idle threshold (configuration bits 31:16) the low run is flushed with that many ticks in total and packet-end flag bit 1 is set. No further entry is written until the line goes high.
- R6: Writing 1 to status bit 0 or bit 1 clears that flag, and a 0 leaves it unchanged. Writing 0xEF clears both.
- R7: Status bit 4 reads 1 exactly when the entry count is at least the level threshold in interrupt enable bits 14:8. The threshold resets to 32.
- R8: `irq` is 1 exactly when some status flag (bits 0, 1, 4) has its enable bit (same position in interrupt enable bits 7:0) set.
- R9: When configuration bit 2 is 1, the line is inverted before it is sampled, so the reported levels are the complement of `ir_in` and the idle level is physical high.
- R10: While configuration bit 0 is 0, no entry is written, whatever `ir_in` does.
- R11: After reset the queue is empty, all flags are 0, `irq` is 0 and the receiver is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared line, asynchronous |
| tick | input | 1 | Sample enable, one pulse per sample period |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears in `reg_rdata` on the next cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The first packet mixes short runs with a run of exactly 127 ticks, a run of 128 ticks, a run of 260 ticks and an idle tail longer than the threshold. These separate the change-driven write, the 127-tick split at its boundary and the idle flush with its remainder. A packet with the line inverted shows that levels are reported after inversion and that high becomes the idle level. Toggling the line with the receiver disabled shows that no entry is written. A packet of 70 two-tick runs fills the queue past its depth and exercises overflow, the level flag, the interrupt enables and the empty read. A short packet against a threshold of 3, drained one entry at a time, shows the level flag clearing at the threshold.

// File: rtl/ir_rs_pkg.sv
package ir_rs_pkg;
  typedef enum logic {RX_IDLE = 1'b0, RX_ACTIVE = 1'b1} rx_state_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_IEN  = 2'd2;
  localparam logic [1:0] ADDR_CFG  = 2'd3;

  localparam int unsigned FLAG_OVF  = 0;
  localparam int unsigned FLAG_PEND = 1;
  localparam int unsigned FLAG_LVL  = 4;

  localparam int unsigned CFG_EN    = 0;
  localparam int unsigned CFG_INV   = 2;
  localparam int unsigned CFG_IDLE  = 16;
  localparam int unsigned FIELD_CNT = 8;
endpackage

// File: rtl/ir_rs_sync.sv
module ir_rs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic invert,
  output logic dout
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = din;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign dout = sh_q[STAGES-1] ^ invert;
endmodule

// File: rtl/ir_rs_runlen.sv
module ir_rs_runlen
  import ir_rs_pkg::*;
#(
  parameter int unsigned LEN_W  = 7,
  parameter int unsigned IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              level,
  input  logic [IDLE_W-1:0] idle_th,
  output logic              push,
  output logic [LEN_W:0]    entry,
  output logic              pkt_end
);
  localparam logic [LEN_W-1:0] MAX_LEN = {LEN_W{1'b1}};

  rx_state_e         state_q, state_d;
  logic              lvl_q, lvl_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              idle_hit;

  assign idle_hit = (state_q == RX_ACTIVE) && !lvl_q && (idle_q >= idle_th);

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    len_d   = len_q;
    idle_d  = idle_q;
    push    = 1'b0;
    entry   = '0;
    pkt_end = 1'b0;
    if (!enable) begin
      state_d = RX_IDLE;
      lvl_d   = 1'b0;
      len_d   = '0;
      idle_d  = '0;
    end else if (idle_hit) begin
      push    = 1'b1;
      entry   = {1'b0, len_q};
      pkt_end = 1'b1;
      state_d = RX_IDLE;
      len_d   = '0;
      idle_d  = '0;
    end else if (tick) begin
      unique case (state_q)
        RX_IDLE: begin
          if (level) begin
            state_d = RX_ACTIVE;
            lvl_d   = 1'b1;
            len_d   = LEN_W'(1);
            idle_d  = '0;
          end
        end
        RX_ACTIVE: begin
          if (level != lvl_q) begin
            push   = 1'b1;
            entry  = {lvl_q, len_q};
            lvl_d  = level;
            len_d  = LEN_W'(1);
            idle_d = level ? '0 : IDLE_W'(1);
          end else begin
            if (len_q == MAX_LEN) begin
              push  = 1'b1;
              entry = {lvl_q, MAX_LEN};
              len_d = LEN_W'(1);
            end else begin
              len_d = len_q + LEN_W'(1);
            end
            if (!lvl_q && (idle_q != {IDLE_W{1'b1}})) idle_d = idle_q + IDLE_W'(1);
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      lvl_q   <= 1'b0;
      len_q   <= '0;
      idle_q  <= '0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      len_q   <= len_d;
      idle_q  <= idle_d;
    end
  end
endmodule

// File: rtl/ir_rs_fifo.sv
module ir_rs_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_en, rd_en;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_en = push && !full;
  assign rd_en = pop && !empty;
  assign head  = mem_q[rd_q];
  assign count = cnt_q;

  always_comb begin
    wr_d  = wr_en ? wr_q + AW'(1) : wr_q;
    rd_d  = rd_en ? rd_q + AW'(1) : rd_q;
    cnt_d = cnt_q + CNT_W'(wr_en) - CNT_W'(rd_en);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ir_run_sampler.sv
module ir_run_sampler
  import ir_rs_pkg::*;
#(
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned LEN_W       = 7,
  parameter int unsigned IDLE_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        tick,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned ENT_W = LEN_W + 1;

  logic              cfg_en_q, cfg_en_d;
  logic              cfg_inv_q, cfg_inv_d;
  logic [IDLE_W-1:0] idle_th_q, idle_th_d;
  logic [7:0]        ien_q, ien_d;
  logic [CNT_W-1:0]  lvl_th_q, lvl_th_d;
  logic              ovf_q, ovf_d;
  logic              pend_q, pend_d;
  logic [31:0]       rdata_q, rdata_d;

  logic              line_s;
  logic              run_push, run_end;
  logic [LEN_W:0]    run_entry;
  logic              fifo_pop, fifo_full, fifo_empty;
  logic [ENT_W-1:0]  fifo_head;
  logic [CNT_W-1:0]  fifo_count;
  logic              lvl_flag;
  logic [7:0]        flag_vec;
  logic [31:0]       stat_word, ien_word, cfg_word;
  logic              wr_stat, wr_ien, wr_cfg;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata;

  ir_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ir_in), .invert(cfg_inv_q), .dout(line_s)
  );

  ir_rs_runlen #(.LEN_W(LEN_W), .IDLE_W(IDLE_W)) u_runlen (
    .clk(clk), .rst_n(rst_n), .enable(cfg_en_q), .tick(tick), .level(line_s),
    .idle_th(idle_th_q), .push(run_push), .entry(run_entry), .pkt_end(run_end)
  );

  ir_rs_fifo #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(run_push), .wdata(run_entry), .pop(fifo_pop),
    .head(fifo_head), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  assign wr_stat  = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_ien   = reg_wr && (reg_addr == ADDR_IEN);
  assign wr_cfg   = reg_wr && (reg_addr == ADDR_CFG);
  assign fifo_pop = reg_rd && (reg_addr == ADDR_DATA) && !fifo_empty;
  assign lvl_flag = (fifo_count >= lvl_th_q);

  always_comb begin
    flag_vec            = '0;
    flag_vec[FLAG_OVF]  = ovf_q;
    flag_vec[FLAG_PEND] = pend_q;
    flag_vec[FLAG_LVL]  = lvl_flag;
  end

  always_comb begin
    stat_word = '0;
    stat_word[7:0] = flag_vec;
    stat_word[FIELD_CNT +: CNT_W] = fifo_count;
    ien_word = '0;
    ien_word[7:0] = ien_q;
    ien_word[FIELD_CNT +: CNT_W] = lvl_th_q;
    cfg_word = '0;
    cfg_word[CFG_EN]  = cfg_en_q;
    cfg_word[CFG_INV] = cfg_inv_q;
    cfg_word[CFG_IDLE +: IDLE_W] = idle_th_q;
  end

  always_comb begin
    cfg_en_d  = cfg_en_q;
    cfg_inv_d = cfg_inv_q;
    idle_th_d = idle_th_q;
    ien_d     = ien_q;
    lvl_th_d  = lvl_th_q;
    ovf_d     = ovf_q;
    pend_d    = pend_q;
    rdata_d   = rdata_q;
    if (wr_cfg) begin
      cfg_en_d  = reg_wdata[CFG_EN];
      cfg_inv_d = reg_wdata[CFG_INV];
      idle_th_d = reg_wdata[CFG_IDLE +: IDLE_W];
    end
    if (wr_ien) begin
      ien_d    = reg_wdata[7:0];
      lvl_th_d = reg_wdata[FIELD_CNT +: CNT_W];
    end
    if (wr_stat && reg_wdata[FLAG_OVF])  ovf_d  = 1'b0;
    if (wr_stat && reg_wdata[FLAG_PEND]) pend_d = 1'b0;
    if (run_push && fifo_full) ovf_d  = 1'b1;
    if (run_end)               pend_d = 1'b1;
    if (reg_rd) begin
      unique case (reg_addr)
        ADDR_DATA: rdata_d = fifo_empty ? '0 : 32'(fifo_head);
        ADDR_STAT: rdata_d = stat_word;
        ADDR_IEN:  rdata_d = ien_word;
        default:   rdata_d = cfg_word;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en_q  <= 1'b0;
      cfg_inv_q <= 1'b0;
      idle_th_q <= IDLE_W'(1000);
      ien_q     <= '0;
      lvl_th_q  <= CNT_W'(DEPTH / 2);
      ovf_q     <= 1'b0;
      pend_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      cfg_en_q  <= cfg_en_d;
      cfg_inv_q <= cfg_inv_d;
      idle_th_q <= idle_th_d;
      ien_q     <= ien_d;
      lvl_th_q  <= lvl_th_d;
      ovf_q     <= ovf_d;
      pend_q    <= pend_d;
      rdata_q   <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = |(flag_vec & ien_q);
endmodule

// File: rtl/ir_run_sampler_chk.sv
module ir_run_sampler_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = 7,
  parameter int unsigned LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push,
  input logic [LEN_W:0]   entry,
  input logic             pop,
  input logic             full,
  input logic [CNT_W-1:0] count,
  input logic             ovf,
  input logic             pend,
  input logic             pkt_end
);
  // R3: stored count never exceeds the queue depth
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R1: every written run lasts at least one tick
  assert_nonzero_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (entry[LEN_W-1:0] != '0));

  // R4: a run arriving at a full queue raises overflow
  assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> ovf);

  // R4: a dropped run leaves the queue full
  assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);

  // R5: idle flush raises packet-end
  assert_pend_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> pend);
endmodule

bind ir_run_sampler ir_run_sampler_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(run_push), .entry(run_entry), .pop(fifo_pop),
  .full(fifo_full), .count(fifo_count), .ovf(ovf_q), .pend(pend_q), .pkt_end(run_end)
);

// File: tb/ir_run_sampler_bench.sv
`timescale 1ns/1ps
module ir_run_sampler_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ir_in;
  logic        tick;
  logic [1:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [1:0]  tc = 2'd0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) tc <= tc + 2'd1;
  assign tick = (tc == 2'd3);

  ir_run_sampler u_ir_run_sampler (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .tick(tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
    @(posedge clk);
    #1;
  endtask

  // expected entries of one run, split at 127 ticks (R2); overflow drops the rest (R4)
  task automatic push_split(input logic lvl, input int n);
    int left = n;
    while (left > 127) begin
      if (exp_q.size() < 64) exp_q.push_back({lvl, 7'd127});
      left -= 127;
    end
    if (exp_q.size() < 64) exp_q.push_back({lvl, 7'(left)});
  endtask

  // driver: hold the physical line for n ticks, record expected entries
  task automatic run(input logic phys, input logic inv, input int n);
    ir_in = phys;
    push_split(phys ^ inv, n);
    repeat (n) wait_tick();
  endtask

  task automatic idle_tail(input logic inv, input int th, input int n);
    ir_in = inv;
    push_split(1'b0, th);
    repeat (n) wait_tick();
  endtask

  // monitor: pop n entries and compare with the scoreboard
  task automatic drain(input int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      rd(2'd0, d);
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected entry", d, 0);
      else begin
        logic [7:0] e = exp_q.pop_front();
        chk(d == {24'd0, e}, "R1/R2 entry", d, e);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; ir_in = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(2'd1, d);
    chk(d == 32'h0, "R11 status after reset", d, 0);
    chk(irq == 1'b0, "R11 irq after reset", irq, 0);
    rd(2'd3, d);
    chk(d[0] == 1'b0, "R11 receiver disabled", d[0], 0);

    // packet A: idle threshold 200, packet-end enabled
    wr(2'd3, (32'd200 << 16) | 32'h1);
    wr(2'd2, (32'd32 << 8) | 32'h02);
    wait_tick();
    run(1, 0, 9); run(0, 0, 4); run(1, 0, 260); run(0, 0, 127); run(1, 0, 128);
    idle_tail(0, 200, 300);
    rd(2'd1, d);
    chk(d[14:8] == 7'd10, "R3 entry count", d[14:8], 10);
    chk(d[1] == 1'b1, "R5 packet-end flag", d[1], 1);
    chk(irq == 1'b1, "R8 irq on packet end", irq, 1);
    drain(10);
    repeat (40) wait_tick();
    rd(2'd1, d);
    chk(d[14:8] == 7'd0, "R5 no entry after idle", d[14:8], 0);
    wr(2'd1, 32'h1);
    rd(2'd1, d);
    chk(d[1] == 1'b1, "R6 write 0 keeps flag", d[1], 1);
    wr(2'd1, 32'h2);
    rd(2'd1, d);
    chk(d[1] == 1'b0, "R6 write 1 clears flag", d[1], 0);
    chk(irq == 1'b0, "R8 irq drops after clear", irq, 0);

    // R9 inverted line, idle physical high
    wr(2'd3, 32'd20 << 16);
    ir_in = 1'b1;
    repeat (4) wait_tick();
    wr(2'd3, (32'd20 << 16) | 32'h5);
    wait_tick();
    run(0, 1, 5); run(1, 1, 7); run(0, 1, 3);
    idle_tail(1, 20, 40);
    rd(2'd1, d);
    chk(d[14:8] == 7'd4, "R9 inverted entry count", d[14:8], 4);
    drain(4);
    wr(2'd1, 32'hEF);

    // R10 disabled receiver ignores the line
    wr(2'd3, 32'd20 << 16);
    wait_tick();
    for (int i = 0; i < 6; i++) begin
      ir_in = ~ir_in;
      repeat (5) wait_tick();
    end
    ir_in = 1'b0;
    repeat (5) wait_tick();
    rd(2'd1, d);
    chk(d[14:8] == 7'd0, "R10 disabled writes nothing", d[14:8], 0);

    // R4/R7 overflow with level and overflow interrupts
    wr(2'd2, (32'd32 << 8) | 32'h11);
    wr(2'd3, (32'd20 << 16) | 32'h1);
    wait_tick();
    for (int i = 0; i < 34; i++) begin
      run(1, 0, 2); run(0, 0, 2);
    end
    run(1, 0, 2);
    idle_tail(0, 20, 40);
    rd(2'd1, d);
    chk(d[14:8] == 7'd64, "R4 queue full count", d[14:8], 64);
    chk(d[0] == 1'b1, "R4 overflow flag", d[0], 1);
    chk(d[4] == 1'b1, "R7 level flag at 64", d[4], 1);
    chk(irq == 1'b1, "R8 irq on overflow/level", irq, 1);
    drain(64);
    rd(2'd0, d);
    chk(d == 32'h0, "R3 empty read returns 0", d, 0);
    rd(2'd1, d);
    chk(d[4] == 1'b0, "R7 level flag clear when empty", d[4], 0);
    chk(irq == 1'b1, "R8 irq held by overflow", irq, 1);
    wr(2'd1, 32'hEF);
    rd(2'd1, d);
    chk(d[7:0] == 8'h0, "R6 0xEF clears all flags", d[7:0], 0);
    chk(irq == 1'b0, "R8 irq low after clear", irq, 0);

    // R7 programmable level threshold 3, level enable only
    wr(2'd2, (32'd3 << 8) | 32'h10);
    wait_tick();
    run(1, 0, 4); run(0, 0, 4); run(1, 0, 4);
    idle_tail(0, 20, 30);
    rd(2'd1, d);
    chk(d[4] == 1'b1, "R7 level flag at 4 of 3", d[4], 1);
    chk(irq == 1'b1, "R8 irq from level", irq, 1);
    drain(2);
    rd(2'd1, d);
    chk(d[4] == 1'b0, "R7 level flag at 2 of 3", d[4], 0);
    chk(irq == 1'b0, "R8 irq level gone", irq, 0);
    drain(2);
    chk(exp_q.size() == 0, "R1 scoreboard empty", exp_q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule